// File: doc/BRIEF.md
# Video Configuration Command Decoder

This block sits behind a host bulk channel and reads its byte stream one byte per cycle. It looks for command frames. Each frame opens with a fixed prefix byte and a command code. The block acts on register-write frames: it stores the data byte into a bank of 8-bit video control registers. The committed bank is driven out as one flat vector. Registered views of the fields that other display logic needs are driven out beside it: colour depth, blank mode, the two 24-bit plane base pointers, twelve 16-bit timing words and the pixel clock word.

Software can make a group of settings take effect together. It first writes the lock value to a dedicated lock address. While the bank is locked, register writes only land in a shadow copy. Writing the unlock value then moves the whole shadow copy into the committed bank on one clock edge. Copy-draw frames are recognised and their payload is discarded. Command codes the block does not know send the parser back to hunting for the prefix. A stray prefix used as padding is harmless.

Top module: `vcfg_cmd_decoder`

## Requirements
- R1: After reset, every committed register, every decoded field and the lock state are zero or unlocked, and `in_ready_o` is 1 once reset is released.
- R2: The four-byte frame 0xAF, 0x20, address, data writes data into register `address`. When the bank is unlocked, the byte appears in `regs_o[address*8 +: 8]` two cycles after the data byte is accepted.
- R3: Bytes received while the parser waits for the prefix are dropped. A command code that is neither write (0x20) nor copy (0x6A) returns the parser to waiting, and the bytes that follow have no effect until the next 0xAF.
- R4: After 0xAF, 0x6A the next seven bytes are consumed as copy payload. This holds even when they look like a register-write frame, and none of them changes any register.
- R5: A write of 0x00 to lock address 0xFF locks the bank. Later register writes leave `regs_o` and all fields unchanged.
- R6: A write of 0xFF to address 0xFF while locked makes every register written during the lock appear in `regs_o` on the same clock edge. No cycle shows a mix of old and new values.
- R7: `base16_o` is {reg 0x20, reg 0x21, reg 0x22} and `base8_o` is {reg 0x26, reg 0x27, reg 0x28}, high byte first. `depth_o` is reg 0x00 and `blank_o` is reg 0x1F.
- R8: Timing word k (k = 0..11) sits at `timing_o[k*16 +: 16]` and equals {reg 0x01+2k, reg 0x02+2k}, high byte at the lower address. `pclk_o` is {reg 0x1C, reg 0x1B}, low byte at the lower address.
- R9: A 0xAF received while a command code is expected is taken as a fresh prefix. So a lone padding prefix followed by a full frame still performs that frame's write.
- R10: Writes to addresses from 64 up to 0xFE change nothing. A write to 0xFF whose value is neither the lock nor the unlock value leaves the lock state as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_ready_o | output | 1 | Byte accepted when high together with valid |
| regs_o | output | 512 | Committed registers, register n at bits n*8+7..n*8 |
| depth_o | output | 8 | Colour depth register |
| blank_o | output | 8 | Blank mode register |
| base16_o | output | 24 | 16bpp plane base pointer |
| base8_o | output | 24 | 8bpp plane base pointer |
| timing_o | output | 192 | Twelve 16-bit timing words |
| pclk_o | output | 16 | Pixel clock in 5 kHz units |

## Verification
The hardest case to reach is the moment of unlock. Several shadowed writes must become visible on exactly one edge, and only an observer that samples every cycle can prove there is no partial update. The stimulus locks the bank and overwrites a spread of registers that feed different fields. It then feeds the final unlock byte by hand and compares the whole register vector every cycle against both the old and the new image. Copy payloads that mimic write frames, and a padding prefix placed just before a real frame, test the parser's resynchronisation.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;
  typedef logic [7:0] byte_t;

  typedef enum logic [2:0] {
    PS_IDLE = 3'd0,
    PS_CMD  = 3'd1,
    PS_ADDR = 3'd2,
    PS_DATA = 3'd3,
    PS_SKIP = 3'd4
  } pstate_e;
endpackage

// File: rtl/vcfg_parser.sv
module vcfg_parser
  import vcfg_pkg::*;
#(
  parameter byte_t PREFIX   = 8'hAF,
  parameter byte_t OP_WRREG = 8'h20,
  parameter byte_t OP_COPY  = 8'h6A,
  parameter int    COPY_LEN = 7
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    acc,
  input  byte_t   din,
  output logic    wr_v_o,
  output byte_t   wr_addr_o,
  output byte_t   wr_data_o,
  output pstate_e state_o
);
  localparam int CNT_W = $clog2(COPY_LEN + 1);

  pstate_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  byte_t            addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= PS_IDLE;
      cnt_q     <= '0;
      addr_q    <= '0;
      wr_v_o    <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_v_o <= 1'b0;
      if (acc) begin
        case (st_q)
          PS_IDLE: if (din == PREFIX) st_q <= PS_CMD;
          PS_CMD: begin
            if (din == OP_WRREG) begin
              st_q <= PS_ADDR;
            end else if (din == OP_COPY) begin
              st_q  <= PS_SKIP;
              cnt_q <= CNT_W'(COPY_LEN - 1);
            end else if (din == PREFIX) begin
              st_q <= PS_CMD;
            end else begin
              st_q <= PS_IDLE;
            end
          end
          PS_ADDR: begin
            addr_q <= din;
            st_q   <= PS_DATA;
          end
          PS_DATA: begin
            wr_v_o    <= 1'b1;
            wr_addr_o <= addr_q;
            wr_data_o <= din;
            st_q      <= PS_IDLE;
          end
          PS_SKIP: begin
            if (cnt_q == '0) st_q <= PS_IDLE;
            else             cnt_q <= cnt_q - 1'b1;
          end
          default: st_q <= PS_IDLE;
        endcase
      end
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/vcfg_bank.sv
module vcfg_bank
  import vcfg_pkg::*;
#(
  parameter int    NREGS      = 64,
  parameter byte_t LOCK_ADDR  = 8'hFF,
  parameter byte_t LOCK_VAL   = 8'h00,
  parameter byte_t UNLOCK_VAL = 8'hFF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_v,
  input  byte_t              wr_addr,
  input  byte_t              wr_data,
  output logic [NREGS*8-1:0] regs_o,
  output logic [NREGS*8-1:0] shadow_o,
  output logic               locked_o,
  output logic               commit_o
);
  logic locked_q;
  logic to_lock;
  logic lock_hit;

  assign to_lock  = wr_v && (wr_addr == LOCK_ADDR);
  assign commit_o = to_lock && (wr_data == UNLOCK_VAL) && locked_q;
  assign lock_hit = to_lock && (wr_data == LOCK_VAL);

  always_ff @(posedge clk) begin
    if (rst)                                      locked_q <= 1'b0;
    else if (lock_hit)                            locked_q <= 1'b1;
    else if (to_lock && wr_data == UNLOCK_VAL)    locked_q <= 1'b0;
  end

  assign locked_o = locked_q;

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    logic  hit;
    byte_t sh_q;
    byte_t act_q;

    assign hit = wr_v && (wr_addr == 8'(i)) && !to_lock;

    always_ff @(posedge clk) begin
      if (rst) begin
        sh_q  <= '0;
        act_q <= '0;
      end else begin
        if (hit) sh_q <= wr_data;
        if (commit_o)              act_q <= sh_q;
        else if (hit && !locked_q) act_q <= wr_data;
      end
    end

    assign shadow_o[i*8 +: 8] = sh_q;
    assign regs_o[i*8 +: 8]   = act_q;
  end
endmodule

// File: rtl/vcfg_fields.sv
module vcfg_fields #(
  parameter int NREGS = 64,
  parameter int DEPTH = 0,
  parameter int BLANK = 31,
  parameter int B16   = 32,
  parameter int B8    = 38,
  parameter int TBASE = 1,
  parameter int NTIM  = 12,
  parameter int PCLK  = 27
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NREGS*8-1:0] regs,
  output logic [7:0]         depth_o,
  output logic [7:0]         blank_o,
  output logic [23:0]        base16_o,
  output logic [23:0]        base8_o,
  output logic [NTIM*16-1:0] timing_o,
  output logic [15:0]        pclk_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      depth_o  <= '0;
      blank_o  <= '0;
      base16_o <= '0;
      base8_o  <= '0;
      pclk_o   <= '0;
    end else begin
      depth_o  <= regs[DEPTH*8 +: 8];
      blank_o  <= regs[BLANK*8 +: 8];
      base16_o <= {regs[B16*8 +: 8], regs[(B16+1)*8 +: 8], regs[(B16+2)*8 +: 8]};
      base8_o  <= {regs[B8*8 +: 8], regs[(B8+1)*8 +: 8], regs[(B8+2)*8 +: 8]};
      pclk_o   <= {regs[(PCLK+1)*8 +: 8], regs[PCLK*8 +: 8]};
    end
  end

  for (genvar k = 0; k < NTIM; k++) begin : g_tim
    localparam int HI = TBASE + 2*k;
    always_ff @(posedge clk) begin
      if (rst) timing_o[k*16 +: 16] <= '0;
      else     timing_o[k*16 +: 16] <= {regs[HI*8 +: 8], regs[(HI+1)*8 +: 8]};
    end
  end
endmodule

// File: rtl/vcfg_cmd_decoder.sv
module vcfg_cmd_decoder
  import vcfg_pkg::*;
#(
  parameter int    NREGS      = 64,
  parameter byte_t PREFIX     = 8'hAF,
  parameter byte_t OP_WRREG   = 8'h20,
  parameter byte_t OP_COPY    = 8'h6A,
  parameter int    COPY_LEN   = 7,
  parameter byte_t LOCK_ADDR  = 8'hFF,
  parameter byte_t LOCK_VAL   = 8'h00,
  parameter byte_t UNLOCK_VAL = 8'hFF,
  parameter byte_t DEPTH_ADDR = 8'h00,
  parameter byte_t BLANK_ADDR = 8'h1F,
  parameter byte_t B16_ADDR   = 8'h20,
  parameter byte_t B8_ADDR    = 8'h26,
  parameter byte_t TIM_ADDR   = 8'h01,
  parameter int    NTIM       = 12,
  parameter byte_t PCLK_ADDR  = 8'h1B
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               in_valid_i,
  input  logic [7:0]         in_data_i,
  output logic               in_ready_o,
  output logic [NREGS*8-1:0] regs_o,
  output logic [7:0]         depth_o,
  output logic [7:0]         blank_o,
  output logic [23:0]        base16_o,
  output logic [23:0]        base8_o,
  output logic [NTIM*16-1:0] timing_o,
  output logic [15:0]        pclk_o
);
  logic               ready_q;
  logic               acc_w;
  logic               wr_v_w;
  byte_t              wr_addr_w;
  byte_t              wr_data_w;
  pstate_e            pstate_w;
  logic [NREGS*8-1:0] shadow_w;
  logic               locked_w;
  logic               commit_w;

  always_ff @(posedge clk_i) begin
    if (rst_i) ready_q <= 1'b0;
    else       ready_q <= 1'b1;
  end

  assign in_ready_o = ready_q;
  assign acc_w      = in_valid_i && ready_q;

  vcfg_parser #(
    .PREFIX(PREFIX), .OP_WRREG(OP_WRREG), .OP_COPY(OP_COPY), .COPY_LEN(COPY_LEN)
  ) parser_i (
    .clk(clk_i), .rst(rst_i), .acc(acc_w), .din(in_data_i),
    .wr_v_o(wr_v_w), .wr_addr_o(wr_addr_w), .wr_data_o(wr_data_w), .state_o(pstate_w)
  );

  vcfg_bank #(
    .NREGS(NREGS), .LOCK_ADDR(LOCK_ADDR), .LOCK_VAL(LOCK_VAL), .UNLOCK_VAL(UNLOCK_VAL)
  ) bank_i (
    .clk(clk_i), .rst(rst_i), .wr_v(wr_v_w), .wr_addr(wr_addr_w), .wr_data(wr_data_w),
    .regs_o(regs_o), .shadow_o(shadow_w), .locked_o(locked_w), .commit_o(commit_w)
  );

  vcfg_fields #(
    .NREGS(NREGS), .DEPTH(int'(DEPTH_ADDR)), .BLANK(int'(BLANK_ADDR)),
    .B16(int'(B16_ADDR)), .B8(int'(B8_ADDR)), .TBASE(int'(TIM_ADDR)),
    .NTIM(NTIM), .PCLK(int'(PCLK_ADDR))
  ) fields_i (
    .clk(clk_i), .rst(rst_i), .regs(regs_o),
    .depth_o(depth_o), .blank_o(blank_o), .base16_o(base16_o), .base8_o(base8_o),
    .timing_o(timing_o), .pclk_o(pclk_o)
  );
endmodule

// File: rtl/vcfg_cmd_decoder_chk.sv
module vcfg_cmd_decoder_chk
  import vcfg_pkg::*;
#(
  parameter int    NREGS  = 64,
  parameter byte_t PREFIX = 8'hAF
) (
  input logic               clk,
  input logic               rst,
  input logic               acc,
  input logic [7:0]         in_data,
  input pstate_e            state,
  input logic               wr_v,
  input logic               locked,
  input logic               commit,
  input logic [NREGS*8-1:0] regs,
  input logic [NREGS*8-1:0] shadow
);
  a_r1_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (regs == '0 && !locked));

  a_r3_idle_drops: assert property (@(posedge clk) disable iff (rst)
    (state == PS_IDLE && acc && in_data != PREFIX) |=> (state == PS_IDLE && !wr_v));

  a_r4_skip_no_write: assert property (@(posedge clk) disable iff (rst)
    (state == PS_SKIP) |=> !wr_v);

  a_r5_locked_hold: assert property (@(posedge clk) disable iff (rst)
    (locked && !commit) |=> $stable(regs));

  a_r6_commit_all: assert property (@(posedge clk) disable iff (rst)
    commit |=> (regs == shadow && !locked));
endmodule

bind vcfg_cmd_decoder vcfg_cmd_decoder_chk #(.NREGS(NREGS), .PREFIX(PREFIX)) chk_i (
  .clk(clk_i), .rst(rst_i), .acc(acc_w), .in_data(in_data_i), .state(pstate_w),
  .wr_v(wr_v_w), .locked(locked_w), .commit(commit_w), .regs(regs_o), .shadow(shadow_w)
);

// File: tb/vcfg_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module vcfg_cmd_decoder_tb_top;
  localparam int N = 64;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [7:0]   in_data = 8'h00;
  logic         in_ready;
  logic [511:0] regs;
  logic [7:0]   depth, blank;
  logic [23:0]  base16, base8;
  logic [191:0] timing;
  logic [15:0]  pclk;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  logic [7:0] m_act [N];
  logic [7:0] m_sh  [N];
  bit         m_lock;

  always #2.5 clk = ~clk;

  vcfg_cmd_decoder dut_i (
    .clk_i(clk), .rst_i(rst), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_ready_o(in_ready), .regs_o(regs), .depth_o(depth), .blank_o(blank),
    .base16_o(base16), .base8_o(base8), .timing_o(timing), .pclk_o(pclk)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [511:0] pack_model();
    logic [511:0] v;
    for (int i = 0; i < N; i++) v[i*8 +: 8] = m_act[i];
    return v;
  endfunction

  task automatic model_wr(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'hFF) begin
      if (d == 8'h00) m_lock = 1'b1;
      else if (d == 8'hFF) begin
        if (m_lock) for (int i = 0; i < N; i++) m_act[i] = m_sh[i];
        m_lock = 1'b0;
      end
    end else if (a < 8'(N)) begin
      m_sh[a] = d;
      if (!m_lock) m_act[a] = d;
    end
  endtask

  task automatic chk_vec(input string req, input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_val(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    send(8'hAF); send(8'h20); send(a); send(d);
    model_wr(a, d);
  endtask

  task automatic chk_fields();
    chk_val("R7 depth", {24'd0, depth}, {24'd0, m_act[0]});
    chk_val("R7 blank", {24'd0, blank}, {24'd0, m_act[31]});
    chk_val("R7 base16", {8'd0, base16}, {8'd0, m_act[32], m_act[33], m_act[34]});
    chk_val("R7 base8", {8'd0, base8}, {8'd0, m_act[38], m_act[39], m_act[40]});
    for (int k = 0; k < 12; k++)
      chk_val("R8 timing word", {16'd0, timing[k*16 +: 16]},
              {16'd0, m_act[1 + 2*k], m_act[2 + 2*k]});
    chk_val("R8 pixel clock", {16'd0, pclk}, {16'd0, m_act[28], m_act[27]});
  endtask

  initial begin
    logic [511:0] old_img, new_img;
    int changes;
    for (int i = 0; i < N; i++) begin m_act[i] = 8'h00; m_sh[i] = 8'h00; end
    m_lock = 1'b0;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk_vec("R1 regs after reset", regs, '0);
    chk_val("R1 ready", {31'd0, in_ready}, 32'd1);
    chk_val("R1 fields", {depth, blank, pclk}, 32'd0);

    // R2 sweep every register address
    for (int a = 0; a < N; a++) begin
      wr(8'(a), 8'((a * 37 + 11) & 8'hFF));
      settle();
      chk_vec("R2 write sweep", regs, pack_model());
    end
    chk_fields();

    // R10 out-of-range address and non-lock value at lock address
    wr(8'h50, 8'hAA); settle();
    chk_vec("R10 out of range", regs, pack_model());
    wr(8'hFF, 8'h55); wr(8'h05, 8'h3C); settle();
    chk_vec("R10 odd lock value keeps unlocked", regs, pack_model());

    // R3 garbage without prefix, then an unknown command
    send(8'h11); send(8'h20); send(8'h05); send(8'h77); settle();
    chk_vec("R3 no prefix", regs, pack_model());
    send(8'hAF); send(8'h33); send(8'h20); send(8'h05); send(8'h77); settle();
    chk_vec("R3 unknown command", regs, pack_model());
    wr(8'h06, 8'h42); settle();
    chk_vec("R3 resync after unknown", regs, pack_model());

    // R4 copy payload that imitates write frames
    send(8'hAF); send(8'h6A);
    send(8'hAF); send(8'h20); send(8'h07); send(8'h99);
    send(8'hAF); send(8'h20); send(8'h08);
    settle();
    chk_vec("R4 copy payload skipped", regs, pack_model());
    wr(8'h09, 8'hC3); settle();
    chk_vec("R4 write after copy", regs, pack_model());

    // R9 lone padding prefix, then a frame after another prefix
    send(8'hAF); settle();
    chk_vec("R9 lone prefix no effect", regs, pack_model());
    wr(8'h0A, 8'h5C); settle();
    chk_vec("R9 frame after padding", regs, pack_model());

    // R5 locked writes are held back
    wr(8'hFF, 8'h00); settle();
    old_img = pack_model();
    wr(8'h20, 8'h12); wr(8'h21, 8'h34); wr(8'h22, 8'h56);
    wr(8'h26, 8'h9A); wr(8'h1B, 8'h78); wr(8'h1C, 8'h01);
    wr(8'h01, 8'hDE); wr(8'h02, 8'hAD); wr(8'h1F, 8'h07);
    settle();
    chk_vec("R5 locked regs unchanged", regs, old_img);
    chk_val("R5 locked base16 unchanged", {8'd0, base16},
            {8'd0, old_img[32*8 +: 8], old_img[33*8 +: 8], old_img[34*8 +: 8]});

    // R6 unlock: single-edge commit, observed every cycle
    send(8'hAF); send(8'h20); send(8'hFF);
    model_wr(8'hFF, 8'hFF);
    new_img = pack_model();
    changes = 0;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'hFF;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      in_valid = 1'b0;
      chk_val("R6 no partial image", {31'd0, (regs === old_img) || (regs === new_img)}, 32'd1);
      if (c > 0 && regs !== old_img && changes == 0) changes = 1;
    end
    chk_vec("R6 committed image", regs, new_img);
    chk_val("R6 commit happened", changes, 1);
    chk_fields();

    // R2 unlocked again: direct write visible
    wr(8'h3F, 8'h81); settle();
    chk_vec("R2 write after unlock", regs, pack_model());

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule